// File: doc/BRIEF.md
# Post-Reset Memory Clearing Sequencer

This block wraps a small register-array memory (one write port, one registered read port) with a sequencer that loads a fixed word into every entry after reset. The clearing is done by the hardware itself, so no simulation-only initial block is needed. While the active-low asynchronous reset is low, the address counter is held at zero. After reset is released, the sequencer writes the fill word to one entry per clock, in ascending address order. After the last entry it parks the counter at zero and raises a sticky ready flag. Downstream logic waits for that flag before it uses the memory.

The sequencer has two states. `ST_FILL` is entered on reset and holds while the counter walks the addresses. `ST_READY` is entered from `ST_FILL` on the clock that writes the last address. That transition is named *fill_complete*. `ST_READY` has no exit except reset, which is an asynchronous transition named *restart* back to `ST_FILL`. While the memory is not ready, user writes are blocked and the read data output is forced to zero. Once it is ready, the memory behaves as an ordinary synchronous RAM with one cycle of read latency.

Top module: `memfill_top`

## Requirements
- R1: While `rst_n` is low, `ready` is 0 and `rd_data` is 0. Both clear at once when `rst_n` falls, without waiting for a clock edge.
- R2: After reset release, every entry (addresses 0 to DEPTH-1, default DEPTH=128, DATA_W=32) holds `FILL_WORD` by the time `ready` rises.
- R3: `ready` is 0 after the 127th rising clock edge following reset release and is 1 after the 128th. The sequencer writes one address per edge, and the counter returns to zero at the end of the fill.
- R4: Once `ready` is 1, it stays 1 until `rst_n` goes low.
- R5: While `ready` is 0, a write request (`wr_en`=1) changes no memory entry.
- R6: While `ready` is 0, `rd_data` is 0 for every `rd_addr`.
- R7: While `ready` is 1, `wr_en`=1 at a rising edge stores `wr_data` at the 7-bit `wr_addr`. Setting `rd_addr` before an edge makes that entry's word appear on `rd_data` after that edge.
- R8: A read and a write to the same address at the same edge return the old word. The new word is returned from the next read.
- R9: `FILL_WORD` is a parameter with a default of all zeros. An all-ones fill value works in the same way.
- R10: Asserting reset after normal use restarts the fill, and every entry, including user-written ones, is overwritten with `FILL_WORD` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | User write request |
| wr_addr | input | 7 | User write address |
| wr_data | input | 32 | User write word |
| rd_addr | input | 7 | Read address |
| rd_data | output | 32 | Registered read word, zero until ready |
| ready | output | 1 | Sticky fill-complete flag |

## Verification
The embedded assertions check on every cycle that the ready flag stays set once it is set, that the counter advances by one per clock during the fill and is parked at zero afterwards, and that the flag rises exactly when a free-running count of cycles since reset reaches the depth. They also check that the read output stays zero while the memory is not ready and that a blocked write never reaches the array. Only the bench's scenarios can show that memory contents are correct: every address holding the fill word, user writes reading back, and read-before-write ordering. The same holds for the effect of a reset in mid-use on stored data. The bench runs a zero-fill instance and an all-ones instance side by side.

// File: rtl/memfill_pkg.sv
package memfill_pkg;
    typedef enum logic [0:0] {
        ST_FILL  = 1'b0,
        ST_READY = 1'b1
    } fill_state_t;
endpackage

// File: rtl/memfill_seq.sv
module memfill_seq
    import memfill_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    output logic                     fill_we,
    output logic [$clog2(DEPTH)-1:0] fill_addr,
    output logic                     ready
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    fill_state_t       state_q;
    logic [ADDR_W-1:0] cnt_q;

    // state register and index counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_FILL: begin
                    if (cnt_q == LAST) begin
                        state_q <= ST_READY;   // fill_complete
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_READY: begin
                    cnt_q <= '0;
                end
                default: begin
                    state_q <= ST_FILL;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        fill_we   = 1'b0;
        ready     = 1'b0;
        fill_addr = cnt_q;
        unique case (state_q)
            ST_FILL:  fill_we = 1'b1;
            ST_READY: ready   = 1'b1;
            default: ;
        endcase
    end

    assert_ready_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
    assert_counter_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
    assert_counter_parked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY) |-> (cnt_q == '0));
    assert_last_to_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && cnt_q == LAST) |=> ready);
endmodule

// File: rtl/memfill_array.sv
module memfill_array #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     rd_ok,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DATA_W-1:0]        rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // registered read; old word on a same-address collision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_ok) rdata <= mem[raddr];
        else            rdata <= '0;
    end

    assert_rdata_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |=> (rdata == '0));
endmodule

// File: rtl/memfill_top.sv
module memfill_top #(
    parameter int                       DEPTH     = 128,
    parameter int                       DATA_W    = 32,
    parameter logic [DATA_W-1:0]        FILL_WORD = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(DEPTH)-1:0]  wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [$clog2(DEPTH)-1:0]  rd_addr,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      ready
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CYC_W  = $clog2(DEPTH + 1);

    logic              fill_we;
    logic [ADDR_W-1:0] fill_addr;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;

    memfill_seq #(.DEPTH(DEPTH)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_we   (fill_we),
        .fill_addr (fill_addr),
        .ready     (ready)
    );

    // write-port steering: the sequencer owns the port until ready
    always_comb begin
        if (fill_we) begin
            mem_we    = 1'b1;
            mem_waddr = fill_addr;
            mem_wdata = FILL_WORD;
        end else begin
            mem_we    = wr_en & ready;
            mem_waddr = wr_addr;
            mem_wdata = wr_data;
        end
    end

    memfill_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .rd_ok (ready),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // cycle counter since reset release, used only by the timing check
    logic [CYC_W-1:0] cyc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cyc_q <= '0;
        else if (cyc_q != CYC_W'(DEPTH)) cyc_q <= cyc_q + 1'b1;
    end

    assert_ready_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == CYC_W'(DEPTH)) == ready);
    assert_early_write_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && wr_en) |-> (mem_wdata == FILL_WORD));
    assert_read_zero_before_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (rd_data == '0));
endmodule

// File: tb/test_memfill_top.sv
module test_memfill_top;
    localparam int DEPTH = 128;
    localparam int AW    = 7;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data, rd_data_1;
    logic ready, ready_1;

    int compared = 0;
    int mismatched = 0;
    bit done_flag = 1'b0;
    logic [31:0] exp0 [DEPTH];
    logic [31:0] exp1 [DEPTH];

    always #4 clk = ~clk;   // 125 MHz

    memfill_top i_memfill_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready));

    memfill_top #(.FILL_WORD(32'hFFFF_FFFF)) i_memfill_top_ones (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data_1), .ready(ready_1));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        compared++;
        if (act !== expv) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    task automatic reset_expect();
        for (int a = 0; a < DEPTH; a++) begin
            exp0[a] = '0;
            exp1[a] = ONES;
        end
    endtask

    // read one address on both instances and compare with the model
    task automatic read_cmp(input string req, input int a);
        rd_addr = AW'(a);
        @(negedge clk);
        chk(req, rd_data, exp0[a]);
        chk(req, rd_data_1, exp1[a]);
    endtask

    // release reset at a falling edge and run the fill, checking R3, R6, R5 stimulus
    task automatic run_fill(input bool_early_wr);
        @(negedge clk);
        rst_n = 1'b1;
        wr_en = bool_early_wr;
        wr_addr = 7'd5;
        wr_data = 32'hDEAD_BEEF;
        for (int k = 1; k <= 127; k++) begin
            rd_addr = AW'(k);
            if (k == 100) wr_addr = 7'd120;
            if (k == 120) wr_en = 1'b0;
            @(negedge clk);
            chk("R6", rd_data, 32'h0);
            chk("R6", rd_data_1, 32'h0);
            if (k == 127) begin
                chk("R3 not ready after 127 edges", {31'b0, ready}, 32'd0);
                chk("R3 not ready after 127 edges", {31'b0, ready_1}, 32'd0);
            end
        end
        wr_en = 1'b0;
        @(negedge clk);
        chk("R3 ready after 128 edges", {31'b0, ready}, 32'd1);
        chk("R3 ready after 128 edges", {31'b0, ready_1}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
    end

    initial begin
        reset_expect();
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", {31'b0, ready}, 32'd0);
        chk("R1", rd_data, 32'h0);
        chk("R1", rd_data_1, 32'h0);

        // fill with an early write attempt held during the fill (R5)
        run_fill(1'b1);

        // R2/R5/R9: every entry holds the fill word; early writes dropped
        for (int a = 0; a < DEPTH; a++) read_cmp("R2 R5 R9 fill content", a);

        // R4: ready stays high across idle cycles
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk("R4", {31'b0, ready & ready_1}, 32'd1);
        end

        // R7: user writes with an arithmetic pattern, then read back
        for (int a = 0; a < DEPTH; a += 3) begin
            wr_en = 1'b1;
            wr_addr = AW'(a);
            wr_data = 32'h1357_0000 + 32'(a * 32'h0001_0203);
            exp0[a] = wr_data;
            exp1[a] = wr_data;
            @(negedge clk);
        end
        wr_en = 1'b0;
        for (int a = 0; a < DEPTH; a++) read_cmp("R7 write read-back", a);

        // R8: same-address read and write in one cycle returns old word
        rd_addr = 7'd9;
        wr_addr = 7'd9;
        wr_en = 1'b1;
        wr_data = 32'hCAFE_F00D;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R8 old word", rd_data, exp0[9]);
        chk("R8 old word", rd_data_1, exp1[9]);
        exp0[9] = 32'hCAFE_F00D;
        exp1[9] = 32'hCAFE_F00D;
        @(negedge clk);
        chk("R8 new word", rd_data, 32'hCAFE_F00D);
        chk("R8 new word", rd_data_1, 32'hCAFE_F00D);

        // R1: asynchronous clear in mid-cycle
        rd_addr = 7'd0;
        @(posedge clk);
        #2;
        rst_n = 1'b0;
        #1;
        chk("R1 async clear ready", {31'b0, ready | ready_1}, 32'd0);
        chk("R1 async clear rd_data", rd_data | (rd_data_1 ^ 32'h0), 32'h0);
        chk("R1 async clear rd_data", rd_data_1, 32'h0);
        repeat (2) @(negedge clk);

        // R10: restart fill without early writes, all user data overwritten
        reset_expect();
        run_fill(1'b0);
        for (int a = 0; a < DEPTH; a++) read_cmp("R10 refill content", a);

        summary();
    end
endmodule